// File: doc/BRIEF.md
# Partial-Word Memory Access Aligner

This unit sits between the execute stage of a 32-bit little-endian core and its data memory port. It accepts one access at a time: an opcode, an effective address, store data, the old value of the destination register and its index. It turns the access into a single word-aligned memory request. For stores it also produces per-byte write strobes and lane-shifted write data. For loads it merges the returned word into a register result. It covers plain word, halfword and byte accesses, and it also covers the four unaligned left/right word forms. Those forms let software assemble a misaligned word from two accesses, each of which touches only the bytes on its side of a word boundary.

A four-state machine controls the unit. In ST_IDLE the unit is ready. An access with a known opcode is latched (transition T_ACCEPT) and moves the unit to ST_ISSUE. An unknown opcode leaves it in ST_IDLE. ST_ISSUE holds the memory request steady until memory accepts it. A store then returns to ST_IDLE (T_STORE_DONE). A load moves to ST_WAIT (T_LOAD_SENT). ST_WAIT waits for the read response and registers the merged value (T_RSP). ST_DONE presents that value for exactly one cycle and then returns to ST_IDLE (T_RETIRE).

The left/right loads read the old register value because the bytes they do not select must survive. The memory word is therefore only one of the operands of the merge.

Top module: `mem_align_unit`

## Requirements
- R1: Every memory request carries the effective address with its two low bits cleared, whatever the access type and offset.
- R2: Opcode 100010 (load-left) with offset k = addr[1:0] returns memory bytes 0..k in result bytes 3-k..3 and keeps old register bytes 0..2-k. With old 0xA5B6C7D8, memory 0xC822C7E8 and k=1 the result is 0xC7E8C7D8.
- R3: Opcode 100110 (load-right) with offset k returns memory bytes k..3 in result bytes 0..3-k and keeps old register bytes 4-k..3. At k=0 the result is the whole memory word.
- R4: Opcode 101010 (store-left) with offset k strobes bytes 0..k and writes data bytes 3-k..3 into them. Unstrobed memory bytes keep their contents.
- R5: Opcode 101110 (store-right) with offset k strobes bytes k..3 and writes data bytes 0..3-k into them. Unstrobed memory bytes keep their contents.
- R6: Opcodes 100011 (word load) and 101011 (word store) use all four strobes on stores. Opcode 101001 (half store) strobes bytes 3:2 when addr[1]=1 and bytes 1:0 otherwise, with the halfword on both halves. Opcode 101000 (byte store) strobes only byte addr[1:0], with data byte 0 on every lane.
- R7: Opcode 100100 (byte load) zero-extends memory byte addr[1:0]. Opcode 100101 (half load) zero-extends memory bytes 3:2 when addr[1]=1 and bytes 1:0 otherwise.
- R8: Any other opcode produces no memory request, and the unit stays ready.
- R9: From acceptance until memory takes the request, req_ready is low and the request fields are stable. Requests offered while busy are not taken.
- R10: A load result appears with wb_valid high for exactly one cycle, in the cycle after the memory response is accepted. It never appears when the destination index is 0.
- R11: After reset req_ready is 1, and mem_req_valid and wb_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Unit can take a request (ST_IDLE) |
| req_op | input | 6 | Access opcode |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store source register value |
| req_old | input | 32 | Previous destination register value |
| req_rd | input | 5 | Destination register index |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 for store, 0 for load |
| mem_addr | output | 32 | Word-aligned address |
| mem_strb | output | 4 | Byte write strobes (0 for loads) |
| mem_wdata | output | 32 | Lane-shifted write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| wb_valid | output | 1 | Register write pulse |
| wb_rd | output | 5 | Register write index |
| wb_data | output | 32 | Merged load result |

## Verification
On every cycle the checker confirms several properties: the request address is aligned, the request is held steady under backpressure, req_ready is low while a request is outstanding, store strobes are non-empty and load strobes are empty, and the writeback is a single pulse that follows a response and never targets index 0. The byte-lane contents of merges and strobes cannot be judged one cycle at a time. They appear only in the bench's scenarios: every opcode at every offset, with random data and old values, compared against byte-wise reference functions and a memory model updated through the strobes. The same holds for ignored unknown opcodes and for requests that arrive while the unit is busy.

// File: rtl/align_pkg.sv
package align_pkg;

    localparam int LANE_W = 8;

    localparam logic [5:0] OPC_LWL = 6'b100010;
    localparam logic [5:0] OPC_LW  = 6'b100011;
    localparam logic [5:0] OPC_LBU = 6'b100100;
    localparam logic [5:0] OPC_LHU = 6'b100101;
    localparam logic [5:0] OPC_LWR = 6'b100110;
    localparam logic [5:0] OPC_SB  = 6'b101000;
    localparam logic [5:0] OPC_SH  = 6'b101001;
    localparam logic [5:0] OPC_SWL = 6'b101010;
    localparam logic [5:0] OPC_SW  = 6'b101011;
    localparam logic [5:0] OPC_SWR = 6'b101110;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_LW,
        ACC_LBU,
        ACC_LHU,
        ACC_LWL,
        ACC_LWR,
        ACC_SW,
        ACC_SB,
        ACC_SH,
        ACC_SWL,
        ACC_SWR
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } fsm_e;

    function automatic logic kind_is_load(input acc_kind_e k);
        return (k == ACC_LW) || (k == ACC_LBU) || (k == ACC_LHU) ||
               (k == ACC_LWL) || (k == ACC_LWR);
    endfunction

    function automatic logic kind_is_store(input acc_kind_e k);
        return (k == ACC_SW) || (k == ACC_SB) || (k == ACC_SH) ||
               (k == ACC_SWL) || (k == ACC_SWR);
    endfunction

endpackage

// File: rtl/align_decode.sv
module align_decode
    import align_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic [OP_W-1:0] op,
    output acc_kind_e       kind
);

    always_comb begin
        unique case (op)
            OPC_LW:  kind = ACC_LW;
            OPC_LBU: kind = ACC_LBU;
            OPC_LHU: kind = ACC_LHU;
            OPC_LWL: kind = ACC_LWL;
            OPC_LWR: kind = ACC_LWR;
            OPC_SW:  kind = ACC_SW;
            OPC_SB:  kind = ACC_SB;
            OPC_SH:  kind = ACC_SH;
            OPC_SWL: kind = ACC_SWL;
            OPC_SWR: kind = ACC_SWR;
            default: kind = ACC_NONE;
        endcase
    end

endmodule

// File: rtl/align_store_gen.sv
module align_store_gen
    import align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTES  = DATA_W / LANE_W,
    parameter int OFF_W  = $clog2(BYTES)
) (
    input  acc_kind_e        kind,
    input  logic [OFF_W-1:0] off,
    input  logic [DATA_W-1:0] wdata,
    output logic [BYTES-1:0] strb,
    output logic [DATA_W-1:0] lane_data
);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE = OFF_W'(g);
        logic [OFF_W-1:0] src;
        logic             sel;

        always_comb begin
            unique case (kind)
                ACC_SW: begin
                    sel = 1'b1;
                    src = LANE;
                end
                ACC_SB: begin
                    sel = (LANE == off);
                    src = '0;
                end
                ACC_SH: begin
                    sel = (LANE[OFF_W-1:1] == off[OFF_W-1:1]);
                    src = {{(OFF_W-1){1'b0}}, LANE[0]};
                end
                ACC_SWL: begin
                    sel = (LANE <= off);
                    src = LANE + ~off;
                end
                ACC_SWR: begin
                    sel = (LANE >= off);
                    src = LANE - off;
                end
                default: begin
                    sel = 1'b0;
                    src = LANE;
                end
            endcase
        end

        assign strb[g]                   = sel;
        assign lane_data[LANE_W*g +: LANE_W] = wdata[LANE_W*src +: LANE_W];
    end

endmodule

// File: rtl/align_load_merge.sv
module align_load_merge
    import align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTES  = DATA_W / LANE_W,
    parameter int OFF_W  = $clog2(BYTES)
) (
    input  acc_kind_e         kind,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] old_word,
    output logic [DATA_W-1:0] result
);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE = OFF_W'(g);
        logic [OFF_W-1:0]  src_left;
        logic [OFF_W-1:0]  src_right;
        logic [OFF_W-1:0]  src_half;
        logic [LANE_W-1:0] old_b;
        logic [LANE_W-1:0] lane_b;

        assign src_left  = LANE + off + OFF_W'(1);
        assign src_right = LANE + off;
        assign src_half  = {off[OFF_W-1:1], LANE[0]};
        assign old_b     = old_word[LANE_W*g +: LANE_W];

        always_comb begin
            unique case (kind)
                ACC_LW:  lane_b = mem_word[LANE_W*g +: LANE_W];
                ACC_LWL: lane_b = (LANE >= ~off) ?
                                  mem_word[LANE_W*src_left +: LANE_W] : old_b;
                ACC_LWR: lane_b = (LANE <= ~off) ?
                                  mem_word[LANE_W*src_right +: LANE_W] : old_b;
                ACC_LBU: lane_b = (g == 0) ?
                                  mem_word[LANE_W*off +: LANE_W] : '0;
                ACC_LHU: lane_b = (g < 2) ?
                                  mem_word[LANE_W*src_half +: LANE_W] : '0;
                default: lane_b = '0;
            endcase
        end

        assign result[LANE_W*g +: LANE_W] = lane_b;
    end

endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
    import align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OP_W   = 6,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_old,
    input  logic [IDX_W-1:0]  req_rd,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_strb,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_rd,
    output logic [DATA_W-1:0] wb_data
);

    localparam int BYTES = DATA_W / LANE_W;
    localparam int OFF_W = $clog2(BYTES);

    fsm_e              state_q, state_d;
    acc_kind_e         dec_kind;
    acc_kind_e         kind_q;
    logic [OFF_W-1:0]  off_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTES-1:0]  strb_q;
    logic [DATA_W-1:0] sdata_q;
    logic [DATA_W-1:0] old_q;
    logic [IDX_W-1:0]  rd_q;
    logic [DATA_W-1:0] wb_data_q;

    logic [BYTES-1:0]  gen_strb;
    logic [DATA_W-1:0] gen_data;
    logic [DATA_W-1:0] merged;
    logic              take_req;

    align_decode #(.OP_W(OP_W)) u_dec (
        .op   (req_op),
        .kind (dec_kind)
    );

    align_store_gen #(.DATA_W(DATA_W), .BYTES(BYTES), .OFF_W(OFF_W)) u_sgen (
        .kind      (dec_kind),
        .off       (req_addr[OFF_W-1:0]),
        .wdata     (req_wdata),
        .strb      (gen_strb),
        .lane_data (gen_data)
    );

    align_load_merge #(.DATA_W(DATA_W), .BYTES(BYTES), .OFF_W(OFF_W)) u_merge (
        .kind     (kind_q),
        .off      (off_q),
        .mem_word (mem_rsp_data),
        .old_word (old_q),
        .result   (merged)
    );

    assign take_req = (state_q == ST_IDLE) && req_valid && (dec_kind != ACC_NONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_req) state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready)
                          state_d = kind_is_load(kind_q) ? ST_WAIT : ST_IDLE;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request and result holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= ACC_NONE;
            off_q     <= '0;
            addr_q    <= '0;
            strb_q    <= '0;
            sdata_q   <= '0;
            old_q     <= '0;
            rd_q      <= '0;
            wb_data_q <= '0;
        end else begin
            if (take_req) begin
                kind_q  <= dec_kind;
                off_q   <= req_addr[OFF_W-1:0];
                addr_q  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                strb_q  <= gen_strb;
                sdata_q <= gen_data;
                old_q   <= req_old;
                rd_q    <= req_rd;
            end
            if ((state_q == ST_WAIT) && mem_rsp_valid)
                wb_data_q <= merged;
        end
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        wb_valid      = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready     = 1'b1;
            ST_ISSUE: mem_req_valid = 1'b1;
            ST_WAIT:  ;
            ST_DONE:  wb_valid      = (rd_q != '0);
            default:  ;
        endcase
        mem_we    = kind_is_store(kind_q);
        mem_addr  = addr_q;
        mem_strb  = mem_we ? strb_q : '0;
        mem_wdata = sdata_q;
        wb_rd     = rd_q;
        wb_data   = wb_data_q;
    end

endmodule

// File: rtl/align_chk.sv
module align_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W/8-1:0] mem_strb,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rsp_valid,
    input logic              wb_valid,
    input logic [IDX_W-1:0]  wb_rd
);

    // R1
    addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_addr[1:0] == 2'b00));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_addr) && $stable(mem_strb) &&
         $stable(mem_wdata) && $stable(mem_we)));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R6
    store_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_we) |-> (mem_strb != '0));

    // R7
    load_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_we) |-> (mem_strb == '0));

    // R10
    wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    // R10
    wb_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(mem_rsp_valid));

    // R10
    wb_rd_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_rd != '0));

endmodule

bind mem_align_unit align_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_strb      (mem_strb),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .wb_valid      (wb_valid),
    .wb_rd         (wb_rd)
);

// File: tb/sim_mem_align_unit.sv
`timescale 1ns/1ps
module sim_mem_align_unit;

    localparam logic [5:0] O_LWL = 6'b100010;
    localparam logic [5:0] O_LW  = 6'b100011;
    localparam logic [5:0] O_LBU = 6'b100100;
    localparam logic [5:0] O_LHU = 6'b100101;
    localparam logic [5:0] O_LWR = 6'b100110;
    localparam logic [5:0] O_SB  = 6'b101000;
    localparam logic [5:0] O_SH  = 6'b101001;
    localparam logic [5:0] O_SWL = 6'b101010;
    localparam logic [5:0] O_SW  = 6'b101011;
    localparam logic [5:0] O_SWR = 6'b101110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_old = '0;
    logic [4:0]  req_rd = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_strb;
    logic [31:0] mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        wb_valid;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] mem_m [16];

    always #5 clk = ~clk;

    mem_align_unit u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit op_known(input logic [5:0] op);
        return op inside {O_LWL, O_LW, O_LBU, O_LHU, O_LWR,
                          O_SB, O_SH, O_SWL, O_SW, O_SWR};
    endfunction

    function automatic bit op_store(input logic [5:0] op);
        return op inside {O_SB, O_SH, O_SWL, O_SW, O_SWR};
    endfunction

    function automatic string req_of(input logic [5:0] op);
        case (op)
            O_LWL: return "R2";
            O_LWR: return "R3";
            O_SWL: return "R4";
            O_SWR: return "R5";
            O_LBU, O_LHU: return "R7";
            O_LW, O_SW, O_SH, O_SB: return "R6";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [7:0] bsel(input logic [31:0] w, input int i);
        return w[8*i +: 8];
    endfunction

    function automatic logic [3:0] ref_strb(input logic [5:0] op, input int k);
        logic [3:0] s = '0;
        for (int i = 0; i < 4; i++) begin
            case (op)
                O_SW:  s[i] = 1'b1;
                O_SB:  s[i] = (i == k);
                O_SH:  s[i] = ((i / 2) == (k / 2));
                O_SWL: s[i] = (i <= k);
                O_SWR: s[i] = (i >= k);
                default: s[i] = 1'b0;
            endcase
        end
        return s;
    endfunction

    function automatic logic [31:0] ref_sdata(input logic [5:0] op, input int k,
                                              input logic [31:0] d);
        logic [31:0] r = '0;
        logic [3:0]  s = ref_strb(op, k);
        for (int i = 0; i < 4; i++) begin
            if (s[i]) begin
                case (op)
                    O_SW:  r[8*i +: 8] = bsel(d, i);
                    O_SB:  r[8*i +: 8] = bsel(d, 0);
                    O_SH:  r[8*i +: 8] = bsel(d, i % 2);
                    O_SWL: r[8*i +: 8] = bsel(d, i + 3 - k);
                    O_SWR: r[8*i +: 8] = bsel(d, i - k);
                    default: r[8*i +: 8] = 8'h00;
                endcase
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_load(input logic [5:0] op, input int k,
                                             input logic [31:0] m, input logic [31:0] old);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            case (op)
                O_LW:  r[8*i +: 8] = bsel(m, i);
                O_LWL: r[8*i +: 8] = (i >= 3 - k) ? bsel(m, i - (3 - k)) : bsel(old, i);
                O_LWR: r[8*i +: 8] = (i <= 3 - k) ? bsel(m, i + k) : bsel(old, i);
                O_LBU: r[8*i +: 8] = (i == 0) ? bsel(m, k) : 8'h00;
                O_LHU: r[8*i +: 8] = (i < 2) ? bsel(m, (k / 2) * 2 + i) : 8'h00;
                default: r[8*i +: 8] = 8'h00;
            endcase
        end
        return r;
    endfunction

    task automatic run_op(input logic [5:0] op, input logic [31:0] addr,
                          input logic [31:0] wd, input logic [31:0] old,
                          input logic [4:0] rd);
        string       rq = req_of(op);
        int          k = int'(addr[1:0]);
        int          idx = int'(addr[5:2]);
        logic [31:0] exp_word;
        logic [3:0]  es;
        int          stall;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_wdata = wd; req_old = old; req_rd = rd;
        @(negedge clk);
        req_valid = 1'b0;
        if (!op_known(op)) begin
            for (int c = 0; c < 3; c++) begin
                chk(mem_req_valid == 1'b0, "R8", "no request on unknown op", 32'(mem_req_valid), 32'h0);
                chk(req_ready == 1'b1, "R8", "ready after unknown op", 32'(req_ready), 32'h1);
                @(negedge clk);
            end
            return;
        end
        chk(mem_req_valid == 1'b1, rq, "request raised", 32'(mem_req_valid), 32'h1);
        chk(mem_addr == {addr[31:2], 2'b00}, "R1", "aligned address", mem_addr, {addr[31:2], 2'b00});
        chk(mem_we == op_store(op), rq, "write enable", 32'(mem_we), 32'(op_store(op)));
        es = ref_strb(op, k);
        if (op_store(op)) begin
            chk(mem_strb == es, rq, "strobes", 32'(mem_strb), 32'(es));
            chk((mem_wdata & {{8{es[3]}}, {8{es[2]}}, {8{es[1]}}, {8{es[0]}}}) == ref_sdata(op, k, wd),
                rq, "lane data", mem_wdata, ref_sdata(op, k, wd));
        end
        stall = int'($urandom % 3);
        for (int c = 0; c < stall; c++) begin
            req_valid = 1'b1; req_op = O_LW;
            @(negedge clk);
            chk(mem_req_valid && req_ready == 1'b0 && mem_addr == {addr[31:2], 2'b00},
                "R9", "request held while stalled", mem_addr, {addr[31:2], 2'b00});
        end
        req_valid = 1'b0;
        mem_req_ready = 1'b1;
        if (op_store(op)) begin
            exp_word = mem_m[idx];
            for (int i = 0; i < 4; i++) begin
                if (es[i]) exp_word[8*i +: 8] = bsel(ref_sdata(op, k, wd), i);
                if (mem_strb[i]) mem_m[idx][8*i +: 8] = mem_wdata[8*i +: 8];
            end
        end else begin
            exp_word = ref_load(op, k, mem_m[idx], old);
        end
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (op_store(op)) begin
            chk(mem_m[idx] == exp_word, rq, "memory word after store", mem_m[idx], exp_word);
            chk(req_ready == 1'b1 && mem_req_valid == 1'b0, "R9", "idle after store, busy request dropped",
                32'(mem_req_valid), 32'h0);
            return;
        end
        for (int c = 0; c < int'($urandom % 3); c++) begin
            chk(wb_valid == 1'b0, "R10", "no writeback before response", 32'(wb_valid), 32'h0);
            @(negedge clk);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = mem_m[idx];
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
        chk(wb_valid == (rd != 5'd0), "R10", "writeback pulse", 32'(wb_valid), 32'(rd != 5'd0));
        if (rd != 5'd0) begin
            chk(wb_data == exp_word, rq, "merged load value", wb_data, exp_word);
            chk(wb_rd == rd, "R10", "writeback index", 32'(wb_rd), 32'(rd));
        end
        @(negedge clk);
        chk(wb_valid == 1'b0, "R10", "pulse lasts one cycle", 32'(wb_valid), 32'h0);
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0, "R9", "idle after load, busy request dropped",
            32'(mem_req_valid), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] ops [12];
        ops = '{O_LWL, O_LW, O_LBU, O_LHU, O_LWR, O_SB, O_SH, O_SWL, O_SW, O_SWR,
                6'b000000, 6'b101100};
        void'($urandom(32'd20210829));
        for (int i = 0; i < 16; i++) mem_m[i] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11", "ready after reset", 32'(req_ready), 32'h1);
        chk(mem_req_valid == 1'b0, "R11", "no request after reset", 32'(mem_req_valid), 32'h0);
        chk(wb_valid == 1'b0, "R11", "no writeback after reset", 32'(wb_valid), 32'h0);

        // R2 sanity of the reference against a known value
        chk(ref_load(O_LWL, 1, 32'hC822C7E8, 32'hA5B6C7D8) == 32'hC7E8C7D8, "R2",
            "reference value", ref_load(O_LWL, 1, 32'hC822C7E8, 32'hA5B6C7D8), 32'hC7E8C7D8);

        // directed: left/right loads and stores at every offset
        for (int k = 0; k < 4; k++) begin
            mem_m[3] = 32'hC822C7E8;
            run_op(O_LWL, 32'h800D_34CC + 32'(k), 32'h0, 32'hA5B6C7D8, 5'd7);
            run_op(O_LWR, 32'h800D_34CC + 32'(k), 32'h0, 32'hA5B6C7D8, 5'd8);
            mem_m[3] = 32'hA5B6C7D8;
            run_op(O_SWL, 32'h800D_34CC + 32'(k), 32'hC822C7E8, 32'h0, 5'd0);
            mem_m[3] = 32'hA5B6C7D8;
            run_op(O_SWR, 32'h800D_34CC + 32'(k), 32'hC822C7E8, 32'h0, 5'd0);
            run_op(O_SB,  32'h0000_0040 + 32'(k), 32'h1234_5678, 32'h0, 5'd0);
            run_op(O_SH,  32'h0000_0040 + 32'(k & 2), 32'h1234_5678, 32'h0, 5'd0);
            run_op(O_LBU, 32'h0000_0040 + 32'(k), 32'h0, 32'hFFFF_FFFF, 5'd9);
        end
        // R10 destination 0 gets no writeback
        run_op(O_LW, 32'h0000_0010, 32'h0, 32'h0, 5'd0);
        // R8 unknown opcodes
        run_op(6'b000000, 32'h0000_0020, 32'h0, 32'h0, 5'd3);
        run_op(6'b111111, 32'h0000_0021, 32'h0, 32'h0, 5'd3);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [5:0]  op = ops[$urandom % 12];
            logic [31:0] a  = $urandom;
            if (op == O_SH || op == O_LHU) a[0] = 1'b0;
            if (op == O_SW || op == O_LW)  a[1:0] = 2'b00;
            run_op(op, a, $urandom, $urandom, 5'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule